// File: doc/BRIEF.md
# Host Command Ring Mailbox

This block is a small command queue that lives in the register space of a network controller. Software writes 32-bit command words straight into a ring of 64 registers, then tells the block how far it has filled the ring by writing a producer index register. There is no push strobe. Publishing is done only by that index write, so software can prepare several slots and release them all with one write.

On the internal side, the block shows the word at the consumer position as soon as the ring is not empty. It splits the word into a command code, a flags field and an index field, and presents them on a valid/ready interface. Each handshake advances the consumer index by one. Software can read the consumer index back to see how far the command engine has got.

A producer write that would move the producer past the consumer is refused and reported with an overflow pulse. The ring therefore never holds more than 63 pending words. Executing the decoded commands is left to the logic downstream.

Top module: `cmd_mailbox`

## Requirements
- R1: After a synchronous reset the producer index, the consumer index and every ring slot read as zero, and `cmd_valid` is low.
- R2: Ring slot n is written and read at byte address 0x700 + 4n, for n from 0 to 63. The two low address bits are ignored for every access.
- R3: A write to byte address 0x50C sets the producer index to `host_wr_data[5:0]`; the upper data bits are ignored. A read of 0x50C returns the producer index zero-extended to 32 bits.
- R4: `cmd_valid` is high exactly when the producer index differs from the consumer index. While it is high, the outputs carry the slot at the consumer index.
- R5: The presented word is split into `cmd_code` = bits 31:24, `cmd_flags` = bits 23:12 and `cmd_index` = bits 11:0.
- R6: The consumer index advances by one on each clock edge where `cmd_valid` and `cmd_ready` are both high, and otherwise holds. It reads back zero-extended at byte address 0x62C. Host writes to 0x62C have no effect.
- R7: Both indices wrap modulo 64, so advancing from 63 gives 0.
- R8: A producer write is refused when its resulting occupancy, (new producer − consumer) mod 64, is smaller than the current occupancy. Writing a value equal to the consumer index while the ring is not empty is such a case. A refused write leaves the producer index unchanged, and `ovf_err` is high for exactly the one cycle after that write.
- R9: `ring_full` is high when the occupancy is 63. A write that brings the occupancy to 63 is accepted.
- R10: Once `cmd_valid` is high, it stays high until a handshake takes place.
- R11: Reads of addresses outside the ring and the two index registers return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_addr | input | 12 | Host write byte address |
| host_wr_data | input | 32 | Host write data |
| host_rd_addr | input | 12 | Host read byte address |
| host_rd_data | output | 32 | Host read data (combinational) |
| cmd_valid | output | 1 | A command word is pending |
| cmd_ready | input | 1 | Consumer accepts the presented command |
| cmd_code | output | 8 | Command code field |
| cmd_flags | output | 12 | Flags field |
| cmd_index | output | 12 | Index field |
| ring_full | output | 1 | Ring holds 63 pending words |
| ovf_err | output | 1 | A producer write was refused (one-cycle pulse) |

## Verification
The hardest state to reach from the ports is a completely full ring followed by a producer write that lands exactly on the consumer position. The stimulus first moves both indices away from zero. It then publishes 63 slots in a single producer write that wraps past slot 63, and immediately attempts the one-too-many write. After that, a drain of all 63 entries carries the consumer index through the wrap point, and the readback of both indices confirms they meet again.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam int CMD_WORD_W = 32;

    typedef struct packed {
        logic [7:0]  code;
        logic [11:0] flags;
        logic [11:0] index;
    } cmd_fields_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_RING,
        SEL_PROD,
        SEL_CONS
    } reg_sel_e;

    function automatic cmd_fields_t split_word(input logic [CMD_WORD_W-1:0] w);
        cmd_fields_t f;
        f.code  = w[31:24];
        f.flags = w[23:12];
        f.index = w[11:0];
        return f;
    endfunction

endpackage

// File: rtl/cmdq_storage.sv
module cmdq_storage #(
    parameter int IDX_W  = 6,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  cons_idx,
    output logic [WORD_W-1:0] cons_word,
    input  logic [IDX_W-1:0]  host_idx,
    output logic [WORD_W-1:0] host_word
);
    localparam int DEPTH = 1 << IDX_W;

    logic [WORD_W-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot[g] <= wr_data;
            end
        end
    end

    assign cons_word = slot[cons_idx];
    assign host_word = slot[host_idx];

endmodule

// File: rtl/cmdq_index_ctrl.sv
module cmdq_index_ctrl #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prod_wr,
    input  logic [IDX_W-1:0] prod_wdata,
    input  logic             pop,
    output logic [IDX_W-1:0] prod,
    output logic [IDX_W-1:0] cons,
    output logic             not_empty,
    output logic             full,
    output logic             ovf_err
);
    localparam logic [IDX_W-1:0] OCC_MAX = {IDX_W{1'b1}};

    logic [IDX_W-1:0] occ_now;
    logic [IDX_W-1:0] occ_new;
    logic             refuse;

    always_comb begin
        occ_now = prod - cons;
        occ_new = prod_wdata - cons;
        refuse  = prod_wr && (occ_new < occ_now);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod    <= '0;
            cons    <= '0;
            ovf_err <= 1'b0;
        end else begin
            if (prod_wr && !refuse) prod <= prod_wdata;
            if (pop) cons <= cons + 1'b1;
            ovf_err <= refuse;
        end
    end

    assign not_empty = (prod != cons);
    assign full      = (occ_now == OCC_MAX);

    // R6: consumer index holds without a handshake
    p_cons_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !pop |=> $stable(cons));

    // R7: consumer index steps by one, wrapping modulo the ring size
    p_cons_step_r7: assert property (@(posedge clk) disable iff (rst)
        pop |=> cons == IDX_W'($past(cons) + 1'b1));

    // R8: a refused write leaves the producer index untouched
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        ovf_err |-> $stable(prod));

    // R9: a full ring is never reported empty
    p_full_pending_r9: assert property (@(posedge clk) disable iff (rst)
        full |-> not_empty);

endmodule

// File: rtl/cmdq_decode.sv
module cmdq_decode
    import cmdq_pkg::*;
(
    input  logic [CMD_WORD_W-1:0] word,
    output logic [7:0]            code,
    output logic [11:0]           flags,
    output logic [11:0]           index
);
    cmd_fields_t f;

    always_comb begin
        f     = split_word(word);
        code  = f.code;
        flags = f.flags;
        index = f.index;
    end

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import cmdq_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int ADDR_W = 12,
    parameter logic [11:0] RING_BASE = 12'h700,
    parameter logic [11:0] PROD_ADDR = 12'h50C,
    parameter logic [11:0] CONS_ADDR = 12'h62C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_en,
    input  logic [ADDR_W-1:0] host_wr_addr,
    input  logic [31:0]       host_wr_data,
    input  logic [ADDR_W-1:0] host_rd_addr,
    output logic [31:0]       host_rd_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [7:0]        cmd_code,
    output logic [11:0]       cmd_flags,
    output logic [11:0]       cmd_index,
    output logic              ring_full,
    output logic              ovf_err
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [ADDR_W:0] RING_END = {1'b0, RING_BASE} + (ADDR_W+1)'(4 * DEPTH);

    function automatic reg_sel_e classify(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] al;
        al = {a[ADDR_W-1:2], 2'b00};
        if (({1'b0, al} >= {1'b0, RING_BASE}) && ({1'b0, al} < RING_END)) return SEL_RING;
        if (al == PROD_ADDR) return SEL_PROD;
        if (al == CONS_ADDR) return SEL_CONS;
        return SEL_NONE;
    endfunction

    function automatic logic [IDX_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] off;
        off = a - RING_BASE;
        return off[IDX_W+1:2];
    endfunction

    reg_sel_e wr_sel, rd_sel;
    logic [IDX_W-1:0] prod, cons;
    logic [31:0] cons_word, host_word;
    logic not_empty, pop;

    assign wr_sel = classify(host_wr_addr);
    assign rd_sel = classify(host_rd_addr);
    assign pop    = not_empty && cmd_ready;

    cmdq_storage #(.IDX_W(IDX_W), .WORD_W(CMD_WORD_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (host_wr_en && (wr_sel == SEL_RING)),
        .wr_idx    (slot_of(host_wr_addr)),
        .wr_data   (host_wr_data),
        .cons_idx  (cons),
        .cons_word (cons_word),
        .host_idx  (slot_of(host_rd_addr)),
        .host_word (host_word)
    );

    cmdq_index_ctrl #(.IDX_W(IDX_W)) u_idx (
        .clk        (clk),
        .rst        (rst),
        .prod_wr    (host_wr_en && (wr_sel == SEL_PROD)),
        .prod_wdata (host_wr_data[IDX_W-1:0]),
        .pop        (pop),
        .prod       (prod),
        .cons       (cons),
        .not_empty  (not_empty),
        .full       (ring_full),
        .ovf_err    (ovf_err)
    );

    cmdq_decode u_dec (
        .word  (cons_word),
        .code  (cmd_code),
        .flags (cmd_flags),
        .index (cmd_index)
    );

    assign cmd_valid = not_empty;

    always_comb begin
        unique case (rd_sel)
            SEL_RING: host_rd_data = host_word;
            SEL_PROD: host_rd_data = 32'(prod);
            SEL_CONS: host_rd_data = 32'(cons);
            default:  host_rd_data = '0;
        endcase
    end

    // R10: a pending command is never dropped before a handshake
    p_valid_hold_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid);

    // R1: indices start from zero after reset
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !cmd_valid && (host_rd_addr != CONS_ADDR || host_rd_data == 32'd0));

endmodule

// File: tb/sim_cmd_mailbox.sv
module sim_cmd_mailbox;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr_en = 1'b0;
    logic [11:0] host_wr_addr = '0;
    logic [31:0] host_wr_data = '0;
    logic [11:0] host_rd_addr = '0;
    logic [31:0] host_rd_data;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [7:0]  cmd_code;
    logic [11:0] cmd_flags;
    logic [11:0] cmd_index;
    logic        ring_full;
    logic        ovf_err;

    int total = 0;
    int bad = 0;
    int exp_pi = 0;
    int exp_ci = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_mailbox u0 (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
        .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_code(cmd_code), .cmd_flags(cmd_flags), .cmd_index(cmd_index),
        .ring_full(ring_full), .ovf_err(ovf_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_addr = a; host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic host_read(input logic [11:0] a, output logic [31:0] d);
        host_rd_addr = a;
        #1;
        d = host_rd_data;
    endtask

    task automatic pop_one();
        @(negedge clk);
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        host_read(12'h50C, d); check("R1 producer", d, 0);
        host_read(12'h62C, d); check("R1 consumer", d, 0);
        host_read(12'h714, d); check("R1 slot5", d, 0);
        check("R1 valid", 32'(cmd_valid), 0);
    endtask

    task automatic t_slots();
        logic [31:0] d;
        host_write(12'h700, 32'h01001000);
        host_write(12'h704, 32'h0B000000);
        host_write(12'h7FC, 32'hCAFEF00D);
        host_write(12'h70B, 32'hA5ABC123);
        host_read(12'h700, d); check("R2 slot0", d, 32'h01001000);
        host_read(12'h7FC, d); check("R2 slot63", d, 32'hCAFEF00D);
        host_read(12'h709, d); check("R2 low bits ignored", d, 32'hA5ABC123);
        host_read(12'h100, d); check("R11 unmapped read", d, 0);
    endtask

    task automatic t_publish();
        logic [31:0] d;
        host_write(12'h50C, 32'hFFFFFF02);
        exp_pi = 2;
        host_read(12'h50C, d); check("R3 producer readback", d, 32'(exp_pi));
        check("R4 valid", 32'(cmd_valid), 1);
        check("R5 code", 32'(cmd_code), 32'h01);
        check("R5 flags", 32'(cmd_flags), 32'h001);
        check("R5 index", 32'(cmd_index), 32'h000);
        pop_one(); exp_ci = 1;
        check("R5 second code", 32'(cmd_code), 32'h0B);
        host_read(12'h62C, d); check("R6 consumer readback", d, 32'(exp_ci));
        pop_one(); exp_ci = 2;
        check("R4 empty", 32'(cmd_valid), 0);
        host_write(12'h62C, 32'h10);
        host_read(12'h62C, d); check("R6 host write ignored", d, 32'(exp_ci));
    endtask

    task automatic t_fields_hold();
        host_write(12'h50C, 32'h3);
        exp_pi = 3;
        check("R5 code A5", 32'(cmd_code), 32'hA5);
        check("R5 flags ABC", 32'(cmd_flags), 32'hABC);
        check("R5 index 123", 32'(cmd_index), 32'h123);
        repeat (3) @(negedge clk);
        check("R10 valid held", 32'(cmd_valid), 1);
        pop_one(); exp_ci = 3;
        check("R4 drained", 32'(cmd_valid), 0);
    endtask

    task automatic t_full_overflow();
        logic [31:0] d;
        int pops;
        host_write(12'h50C, 32'h2);
        exp_pi = 2;
        check("R9 full accepted", 32'(ring_full), 1);
        host_read(12'h50C, d); check("R9 producer", d, 32'(exp_pi));
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_addr = 12'h50C; host_wr_data = 32'h3;
        @(negedge clk);
        host_wr_en = 1'b0;
        check("R8 ovf pulse", 32'(ovf_err), 1);
        host_read(12'h50C, d); check("R8 producer kept", d, 32'(exp_pi));
        @(negedge clk);
        check("R8 ovf one cycle", 32'(ovf_err), 0);
        check("R9 still full", 32'(ring_full), 1);
        pops = 0;
        for (int i = 0; i < 63; i++) begin
            if (cmd_valid) pops++;
            pop_one();
        end
        exp_ci = 2;
        check("R7 drain count", 32'(pops), 63);
        check("R7 empty after wrap", 32'(cmd_valid), 0);
        host_read(12'h62C, d); check("R7 consumer wrapped", d, 32'(exp_ci));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_slots();
        t_publish();
        t_fields_hold();
        t_full_overflow();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule